// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers a vector of level-sensitive interrupt sources and drives two request lines toward a processor: a normal request and a fast request. A single raw level is shared by both lines. Each line has its own enable mask. The masks are changed only through separate write-one-to-set and write-one-to-clear words, so software can change individual bits without a read-modify-write. Source line 0 can also be raised and dropped by software, which lets firmware post an interrupt to itself.

The register bus is word-addressed, with one address for reads and writes and a single-cycle write strobe. Read data is a combinational view of registered state. Both request outputs come from flops. The value a flop takes at a clock edge already includes the mask write or the source change sampled at that same edge. Controllers can be chained: the normal request of one instance feeds a source input of another. Priority encoding, vectoring and edge detection are not part of the block.

Top module: `intc_dual`

## Requirements
- R1: After synchronous reset, both enable masks and the software flag are zero, the raw level is zero, and both request outputs are low.
- R2: The raw level is the source vector sampled at each clock edge, with bit 0 ORed with the software flag. Word 1 and word 9 both read the raw level.
- R3: A write to word 2 ORs the data into the normal-request mask. Word 2 reads that mask back.
- R4: A write to word 3 clears each normal-request mask bit whose data bit is 1 and leaves the other bits unchanged.
- R5: A write to word 10 ORs the data into the fast-request mask, and word 10 reads that mask back. A write to word 11 clears the mask bits written as 1.
- R6: Word 0 reads the raw level AND the normal mask. Word 8 reads the raw level AND the fast mask.
- R7: A write to word 4 with data bit 0 = 1 sets the software flag. A write to word 5 with data bit 0 = 1 clears it. Data bits 31..1 of those writes have no effect. Word 4 reads the flag in bit 0, with zero above it.
- R8: The normal request output is high exactly when some bit of raw level AND normal mask is set. It reflects a source change or register write at the first clock edge that samples it.
- R9: The fast request output follows the same rule and timing as R8, using the fast mask.
- R10: Reads of words 3, 5 and 11, and of the unassigned words 6, 7 and 12 to 15, return zero.
- R11: Writes to words 0, 1, 8 and 9 change neither mask, the software flag nor either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Word address for the read and write |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the word at bus_addr |
| src_lvl | input | NUM_SRC (32) | Level-sensitive interrupt sources |
| irq_o | output | 1 | Normal request, registered |
| fiq_o | output | 1 | Fast request, registered |

## Verification
A corrupt mask bit shows up in the mask's own readback word on the next read, and it gates the matching request the moment that source goes high. A bad software flag shows on bit 0 of words 1, 4 and 9. A wrong output flop disagrees with the status word after a single clock edge. The sweep walks every source bit through both masks, including a neighbouring bit that must not match. Pseudo-random set and clear traffic is then compared word by word against a bench model.

// File: rtl/intc_pkg.sv
// Shared constants and types for the dual-output interrupt controller.
// Assumes a word-addressed register bus; offsets are word indices.
package intc_pkg;
    localparam logic [31:0] OFS_NRM_STAT  = 32'd0;
    localparam logic [31:0] OFS_NRM_RAW   = 32'd1;
    localparam logic [31:0] OFS_NRM_SET   = 32'd2;
    localparam logic [31:0] OFS_NRM_CLR   = 32'd3;
    localparam logic [31:0] OFS_SW_SET    = 32'd4;
    localparam logic [31:0] OFS_SW_CLR    = 32'd5;
    localparam logic [31:0] OFS_FST_STAT  = 32'd8;
    localparam logic [31:0] OFS_FST_RAW   = 32'd9;
    localparam logic [31:0] OFS_FST_SET   = 32'd10;
    localparam logic [31:0] OFS_FST_CLR   = 32'd11;

    localparam int CH_NRM = 0;
    localparam int CH_FST = 1;
    localparam int NUM_CH = 2;

    typedef struct packed {
        logic [NUM_CH-1:0] en_set;
        logic [NUM_CH-1:0] en_clr;
        logic              sw_set;
        logic              sw_clr;
    } wr_strobe_t;
endpackage

// File: rtl/intc_wr_decode.sv
// Write decoder: turns one bus write into per-function strobes.
// Assumes at most one write per cycle; software-flag strobes need data bit 0.
module intc_wr_decode
    import intc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wdata_b0,
    output wr_strobe_t        stb
);
    logic [31:0] word_idx;

    assign word_idx = 32'(bus_addr);

    // Decode the word index into set/clear strobes for masks and flag.
    always_comb begin
        stb = '0;
        if (bus_wr) begin
            stb.en_set[CH_NRM] = (word_idx == OFS_NRM_SET);
            stb.en_clr[CH_NRM] = (word_idx == OFS_NRM_CLR);
            stb.en_set[CH_FST] = (word_idx == OFS_FST_SET);
            stb.en_clr[CH_FST] = (word_idx == OFS_FST_CLR);
            stb.sw_set         = (word_idx == OFS_SW_SET) && wdata_b0;
            stb.sw_clr         = (word_idx == OFS_SW_CLR) && wdata_b0;
        end
    end
endmodule

// File: rtl/intc_src_level.sv
// Raw level register: samples the source vector each clock and merges the
// software flag into bit 0. Exposes both the current and next raw level.
module intc_src_level #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               sw_set,
    input  logic               sw_clr,
    output logic [NUM_SRC-1:0] raw_q,
    output logic [NUM_SRC-1:0] raw_next,
    output logic               sw_q
);
    logic [NUM_SRC-1:0] src_q;
    logic               sw_next;

    // Next value of the software flag; set wins although both never coincide.
    always_comb begin
        sw_next = sw_q;
        if (sw_clr) sw_next = 1'b0;
        if (sw_set) sw_next = 1'b1;
    end

    // Sample the sources and hold the software flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            sw_q  <= 1'b0;
        end else begin
            src_q <= src_lvl;
            sw_q  <= sw_next;
        end
    end

    assign raw_q    = src_q   | NUM_SRC'(sw_q);
    assign raw_next = src_lvl | NUM_SRC'(sw_next);
endmodule

// File: rtl/intc_channel.sv
// One request channel: a set/clear enable mask and a registered request
// output computed from the next raw level and next mask.
module intc_channel #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_set,
    input  logic               en_clr,
    input  logic [NUM_SRC-1:0] wmask,
    input  logic [NUM_SRC-1:0] raw_next,
    output logic [NUM_SRC-1:0] en_q,
    output logic               req_q
);
    logic [NUM_SRC-1:0] en_next;

    // Apply the write-one-to-set or write-one-to-clear update.
    always_comb begin
        en_next = en_q;
        if (en_set) en_next = en_q | wmask;
        if (en_clr) en_next = en_q & ~wmask;
    end

    // Hold the mask and the request flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            req_q <= 1'b0;
        end else begin
            en_q  <= en_next;
            req_q <= |(raw_next & en_next);
        end
    end
endmodule

// File: rtl/intc_dual.sv
// Dual-output level interrupt controller top. Combines the write decoder,
// raw level register and two request channels; read data is combinational.
// Assumes NUM_SRC <= DATA_W and ADDR_W < 32.
module intc_dual
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic               irq_o,
    output logic               fiq_o
);
    wr_strobe_t         stb;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] raw_next;
    logic               sw_q;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] chan_en  [NUM_CH];
    logic               chan_req [NUM_CH];
    logic [NUM_SRC-1:0] irq_en;
    logic [NUM_SRC-1:0] fiq_en;
    logic [31:0]        word_idx;

    assign wmask = bus_wdata[NUM_SRC-1:0];

    intc_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wdata_b0 (bus_wdata[0]),
        .stb      (stb)
    );

    intc_src_level #(.NUM_SRC(NUM_SRC)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  (src_lvl),
        .sw_set   (stb.sw_set),
        .sw_clr   (stb.sw_clr),
        .raw_q    (raw_q),
        .raw_next (raw_next),
        .sw_q     (sw_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        intc_channel #(.NUM_SRC(NUM_SRC)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_set   (stb.en_set[c]),
            .en_clr   (stb.en_clr[c]),
            .wmask    (wmask),
            .raw_next (raw_next),
            .en_q     (chan_en[c]),
            .req_q    (chan_req[c])
        );
    end

    assign irq_en = chan_en[CH_NRM];
    assign fiq_en = chan_en[CH_FST];
    assign irq_o  = chan_req[CH_NRM];
    assign fiq_o  = chan_req[CH_FST];

    assign word_idx = 32'(bus_addr);

    // Select the read word; write-only and unassigned words read zero.
    always_comb begin
        case (word_idx)
            OFS_NRM_STAT: bus_rdata = DATA_W'(raw_q & irq_en);
            OFS_NRM_RAW:  bus_rdata = DATA_W'(raw_q);
            OFS_NRM_SET:  bus_rdata = DATA_W'(irq_en);
            OFS_SW_SET:   bus_rdata = DATA_W'(sw_q);
            OFS_FST_STAT: bus_rdata = DATA_W'(raw_q & fiq_en);
            OFS_FST_RAW:  bus_rdata = DATA_W'(raw_q);
            OFS_FST_SET:  bus_rdata = DATA_W'(fiq_en);
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_dual_chk.sv
// Assertion checker for intc_dual, attached by bind below.
module intc_dual_chk
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] irq_en,
    input logic [NUM_SRC-1:0] fiq_en,
    input logic [NUM_SRC-1:0] raw_q,
    input logic               irq_o,
    input logic               fiq_o
);
    logic [NUM_SRC-1:0] wm;
    logic [31:0]        w;
    assign wm = bus_wdata[NUM_SRC-1:0];
    assign w  = 32'(bus_addr);

    a_r8_irq_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(raw_q & irq_en));
    a_r9_fiq_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == |(raw_q & fiq_en));
    a_r3_irq_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == OFS_NRM_SET) |=> ((irq_en & $past(wm)) == $past(wm)));
    a_r4_irq_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == OFS_NRM_CLR) |=> ((irq_en & $past(wm)) == '0));
    a_r5_fiq_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == OFS_FST_SET) |=> ((fiq_en & $past(wm)) == $past(wm)));
    a_r5_fiq_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == OFS_FST_CLR) |=> ((fiq_en & $past(wm)) == '0));
    a_r7_soft_raises_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == OFS_SW_SET && bus_wdata[0]) |=> raw_q[0]);
    a_r11_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (w == OFS_NRM_STAT || w == OFS_NRM_RAW ||
                    w == OFS_FST_STAT || w == OFS_FST_RAW))
        |=> ($stable(irq_en) && $stable(fiq_en)));

    // R10: write-only words read zero.
    always_ff @(posedge clk) begin
        if (rst_n && (w == OFS_NRM_CLR || w == OFS_SW_CLR || w == OFS_FST_CLR)) begin
            a_r10_wo_reads_zero: assert (bus_rdata == '0);
        end
    end
endmodule

bind intc_dual intc_dual_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_en    (irq_en),
    .fiq_en    (fiq_en),
    .raw_q     (raw_q),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/sim_intc_dual.sv
module sim_intc_dual;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] src_lvl;
    logic        irq_o;
    logic        fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_src, m_irq, m_fiq;
    logic        m_sw;
    logic [31:0] seed;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_dual u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_lvl = v; m_src = v;
        @(negedge clk);
    endtask

    function automatic logic [31:0] raw_exp();
        return m_src | {31'b0, m_sw};
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] d;
        rd(4'd0, d);  check({tag, " R6 nrm status"}, d, raw_exp() & m_irq);
        rd(4'd1, d);  check({tag, " R2 raw w1"}, d, raw_exp());
        rd(4'd2, d);  check({tag, " R3 nrm mask"}, d, m_irq);
        rd(4'd4, d);  check({tag, " R7 sw flag"}, d, {31'b0, m_sw});
        rd(4'd8, d);  check({tag, " R6 fst status"}, d, raw_exp() & m_fiq);
        rd(4'd9, d);  check({tag, " R2 raw w9"}, d, raw_exp());
        rd(4'd10, d); check({tag, " R5 fst mask"}, d, m_fiq);
        check({tag, " R8 irq_o"}, {31'b0, irq_o}, {31'b0, |(raw_exp() & m_irq)});
        check({tag, " R9 fiq_o"}, {31'b0, fiq_o}, {31'b0, |(raw_exp() & m_fiq)});
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; src_lvl = '0;
        m_src = '0; m_irq = '0; m_fiq = '0; m_sw = 1'b0; seed = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // Walk each source bit through both masks (R8, R9, R6, R2).
        for (int i = 0; i < 32; i++) begin
            wr(4'd3, 32'hFFFF_FFFF); m_irq = '0;
            wr(4'd11, 32'hFFFF_FFFF); m_fiq = '0;
            set_src(32'h1 << i);
            check("R8 unmasked irq low", {31'b0, irq_o}, 32'h0);
            wr(4'd2, 32'h1 << i); m_irq = 32'h1 << i;
            check("R8 irq high one edge after mask", {31'b0, irq_o}, 32'h1);
            wr(4'd10, 32'h1 << ((i + 1) % 32)); m_fiq = 32'h1 << ((i + 1) % 32);
            check("R9 neighbour mask fiq low", {31'b0, fiq_o}, 32'h0);
            wr(4'd10, 32'h1 << i); m_fiq = m_fiq | (32'h1 << i);
            check_all("sweep");
            set_src('0);
            check("R8 irq falls with source", {31'b0, irq_o}, 32'h0);
        end

        // Pseudo-random set/clear traffic (R3, R4, R5).
        for (int k = 0; k < 60; k++) begin
            seed = nxt(seed); set_src(seed & nxt(seed ^ 32'h5A5A_0F0F));
            seed = nxt(seed); wr(4'd2, seed);  m_irq = m_irq | seed;
            seed = nxt(seed); wr(4'd3, seed);  m_irq = m_irq & ~seed;
            check_all("R4 mix");
            seed = nxt(seed); wr(4'd10, seed); m_fiq = m_fiq | seed;
            seed = nxt(seed); wr(4'd11, seed); m_fiq = m_fiq & ~seed;
            check_all("R5 mix");
        end

        // Software interrupt on line 0 (R7).
        wr(4'd3, 32'hFFFF_FFFF); m_irq = '0;
        wr(4'd11, 32'hFFFF_FFFF); m_fiq = '0;
        set_src('0);
        wr(4'd2, 32'h1); m_irq = 32'h1;
        wr(4'd4, 32'hFFFF_FFFE);
        check_all("R7 upper bits no effect");
        wr(4'd4, 32'h1); m_sw = 1'b1;
        check_all("R7 soft set");
        set_src(32'h1);
        wr(4'd5, 32'hFFFF_FFFF); m_sw = 1'b0;
        check_all("R7 soft clr src holds");
        set_src('0);
        check_all("R7 line released");
        wr(4'd4, 32'h1); m_sw = 1'b1;
        wr(4'd5, 32'hFFFF_FFFE);
        check_all("R7 clr needs bit0");
        wr(4'd5, 32'h1); m_sw = 1'b0;
        check_all("R7 soft cleared");

        // Write-only and unassigned words read zero (R10).
        wr(4'd2, 32'hF0F0_1234); m_irq = m_irq | 32'hF0F0_1234;
        wr(4'd10, 32'h0F0F_4321); m_fiq = m_fiq | 32'h0F0F_4321;
        set_src(32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) begin
            if (a == 3 || a == 5 || a == 6 || a == 7 || a >= 11) begin
                rd(4'(a), d);
                check($sformatf("R10 word %0d reads zero", a), d, 32'h0);
            end
        end

        // Writes to status and raw words are ignored (R11).
        set_src(32'h0000_0010);
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd9, 32'hFFFF_FFFF);
        check_all("R11 status writes ignored");
        set_src('0);
        wr(4'd1, 32'h1);
        wr(4'd9, 32'h1);
        check_all("R11 no soft via raw word");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule